// File: doc/BRIEF.md
# Binary-Field Arithmetic Unit with Operand Register File

This block is a small arithmetic datapath for elliptic-curve point multiplication over GF(2^163). Operands sit in a register file that has two read ports and one write port. A single command port starts one operation at a time. Each command names two source registers, a destination register and an operation. The unit can load an operand, add two field elements, multiply them digit-serially, or square one of them in a single step.

A sequencer above this block issues commands and waits for the `done` pulse. In the `done` cycle the result is written to the destination register and is also shown on `res_data`. While a command is in flight, `busy` is high and any new command is dropped. The multiplier uses a digit size `DIGIT` fixed at compile time. Each step folds one `DIGIT`-bit slice of Y, taken most significant slice first, into a running product. Y is padded with zeros at the top when 163 is not a multiple of `DIGIT`.

Top module: `gf_alu_core`

## Requirements
- R1: After reset is released, `busy` and `done` are both low.
- R2: Operation code 3 (load) writes `cmd_data` into register `cmd_dst`. `done` rises one cycle after acceptance, with `res_data` equal to `cmd_data`.
- R3: Operation code 0 (add) produces the bitwise XOR of registers `cmd_src_a` and `cmd_src_b`. `done` rises one cycle after acceptance.
- R4: Operation code 1 (multiply) produces the product of registers `cmd_src_a` and `cmd_src_b`, reduced modulo x^163 + x^7 + x^6 + x^3 + 1.
- R5: A multiply raises `done` exactly ceil(163/DIGIT)+1 cycles after the cycle in which it was accepted. For the default DIGIT=7 this is 25 cycles. `done` stays low before that cycle.
- R6: Operation code 2 (square) produces the square of register `cmd_src_a`, reduced by the same polynomial. `done` rises one cycle after acceptance, and `cmd_src_b` has no effect.
- R7: `done` is a single-cycle pulse. The value on `res_data` during `done` is stored in `cmd_dst` in that same cycle, and later reads of that register return it.
- R8: A command is accepted only when `cmd_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. Commands presented while `busy` is high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 add, 1 multiply, 2 square, 3 load |
| cmd_src_a | input | $clog2(NREG) | First source register (X operand) |
| cmd_src_b | input | $clog2(NREG) | Second source register (Y operand) |
| cmd_dst | input | $clog2(NREG) | Destination register |
| cmd_data | input | 163 | Value written by a load |
| busy | output | 1 | A command is in flight |
| done | output | 1 | Result is being written this cycle |
| res_data | output | 163 | Result being written |

## Verification
The operand pairs cover several distinct patterns. These are the identity (one times a value), zero, x times x^162 (which forces exactly one reduction fold), all-ones times all-ones (which reduces at nearly every position), and dense mixed words. Each pattern goes through add, multiply in both operand orders, and square. Together they separate errors in the top-slice zero padding, in the reduction taps, and in the digit order. Readback through an add with a zeroed register confirms the write-back. A load held on the port during a multiply must leave its target register unchanged, which separates correct command gating from a leaky one.

// File: rtl/gf_arith_pkg.sv
package gf_arith_pkg;
    localparam int FIELD_M = 163;
    // Low-order terms of the reduction polynomial: x^7 + x^6 + x^3 + 1
    localparam logic [FIELD_M-1:0] POLY_LOW = FIELD_M'(8'hC9);

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MUL  = 2'd1,
        OP_SQR  = 2'd2,
        OP_LOAD = 2'd3
    } gf_op_e;

    // Multiply by x, reduced
    function automatic logic [FIELD_M-1:0] gf_xtime(input logic [FIELD_M-1:0] a);
        return {a[FIELD_M-2:0], 1'b0} ^ (a[FIELD_M-1] ? POLY_LOW : '0);
    endfunction
endpackage

// File: rtl/gf_regfile.sv
module gf_regfile #(
    parameter int W = 163,
    parameter int N = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data
);
    logic [W-1:0] mem_q [N];

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[gi] <= '0;
                else if (we && waddr == AW'(gi))
                    mem_q[gi] <= wdata;
            end
        end
    endgenerate

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];
endmodule

// File: rtl/gf_squarer.sv
module gf_squarer
    import gf_arith_pkg::*;
(
    input  logic [FIELD_M-1:0] a,
    output logic [FIELD_M-1:0] sq
);
    localparam int WIDE = 2 * FIELD_M - 1;

    function automatic logic [FIELD_M-1:0] square_fn(input logic [FIELD_M-1:0] v);
        logic [WIDE-1:0] t;
        t = '0;
        for (int i = 0; i < FIELD_M; i++) t[2*i] = v[i];
        for (int i = WIDE - 1; i >= FIELD_M; i--) begin
            if (t[i]) begin
                t[i] = 1'b0;
                for (int j = 0; j < 8; j++)
                    if (POLY_LOW[j]) t[i-FIELD_M+j] = ~t[i-FIELD_M+j];
            end
        end
        return t[FIELD_M-1:0];
    endfunction

    assign sq = square_fn(a);
endmodule

// File: rtl/gf_digit_mul.sv
module gf_digit_mul
    import gf_arith_pkg::*;
#(
    parameter int DIGIT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_M-1:0] x_in,
    input  logic [FIELD_M-1:0] y_in,
    output logic               last,
    output logic [FIELD_M-1:0] prod
);
    localparam int NDIG = (FIELD_M + DIGIT - 1) / DIGIT;
    localparam int YW   = NDIG * DIGIT;
    localparam int CW   = $clog2(NDIG + 1);

    typedef struct packed {
        logic               active;
        logic [CW-1:0]      cnt;
        logic [FIELD_M-1:0] x;
        logic [YW-1:0]      y;
        logic [FIELD_M-1:0] acc;
    } mul_s;

    mul_s q, d;

    // acc * x^DIGIT + x * digit, Horner form over the digit bits
    function automatic logic [FIELD_M-1:0] step_fn(
        input logic [FIELD_M-1:0] acc,
        input logic [FIELD_M-1:0] x,
        input logic [DIGIT-1:0]   dig
    );
        logic [FIELD_M-1:0] r;
        r = acc;
        for (int b = DIGIT - 1; b >= 0; b--)
            r = gf_xtime(r) ^ (dig[b] ? x : '0);
        return r;
    endfunction

    always_comb begin
        d    = q;
        last = q.active && (q.cnt == CW'(NDIG - 1));
        if (start) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.x      = x_in;
            d.y      = YW'(y_in);
            d.acc    = '0;
        end else if (q.active) begin
            d.acc = step_fn(q.acc, q.x, q.y[YW-1 -: DIGIT]);
            d.y   = (q.y << DIGIT) | (q.y >> (YW - DIGIT));
            d.cnt = q.cnt + CW'(1);
            if (last) d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prod = q.acc;
endmodule

// File: rtl/gf_alu_core.sv
module gf_alu_core
    import gf_arith_pkg::*;
#(
    parameter int DIGIT = 7,
    parameter int NREG  = 8,
    localparam int AW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [AW-1:0]      cmd_src_a,
    input  logic [AW-1:0]      cmd_src_b,
    input  logic [AW-1:0]      cmd_dst,
    input  logic [FIELD_M-1:0] cmd_data,
    output logic               busy,
    output logic               done,
    output logic [FIELD_M-1:0] res_data
);
    typedef enum logic [1:0] {S_IDLE, S_MULT, S_WRB} st_e;

    typedef struct packed {
        st_e                st;
        logic               from_mul;
        logic [AW-1:0]      dst;
        logic [FIELD_M-1:0] res;
    } core_s;

    core_s q, d;

    logic [FIELD_M-1:0] rd_a, rd_b, sq_out, prod, wr_data;
    logic               mul_start, mul_last, wr_en;

    gf_regfile #(.W(FIELD_M), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (q.dst),
        .wdata   (wr_data),
        .ra_addr (cmd_src_a),
        .rb_addr (cmd_src_b),
        .ra_data (rd_a),
        .rb_data (rd_b)
    );

    gf_squarer u_sq (
        .a  (rd_a),
        .sq (sq_out)
    );

    gf_digit_mul #(.DIGIT(DIGIT)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .x_in  (rd_a),
        .y_in  (rd_b),
        .last  (mul_last),
        .prod  (prod)
    );

    always_comb begin
        d         = q;
        mul_start = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    d.dst      = cmd_dst;
                    d.from_mul = 1'b0;
                    d.st       = S_WRB;
                    unique case (gf_op_e'(cmd_op))
                        OP_ADD:  d.res = rd_a ^ rd_b;
                        OP_SQR:  d.res = sq_out;
                        OP_LOAD: d.res = cmd_data;
                        OP_MUL: begin
                            mul_start  = 1'b1;
                            d.from_mul = 1'b1;
                            d.st       = S_MULT;
                        end
                        default: d.res = '0;
                    endcase
                end
            end
            S_MULT:  if (mul_last) d.st = S_WRB;
            S_WRB:   d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_en    = (q.st == S_WRB);
    assign wr_data  = q.from_mul ? prod : q.res;
    assign done     = wr_en;
    assign busy     = (q.st != S_IDLE);
    assign res_data = wr_data;
endmodule

// File: rtl/gf_alu_checker.sv
module gf_alu_checker #(
    parameter int DIGIT = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       busy,
    input logic       done
);
    localparam int NDIG = (163 + DIGIT - 1) / DIGIT;

    logic        pend_q;
    logic [15:0] cnt_q;
    logic        accept;

    assign accept = cmd_valid && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept && cmd_op == 2'd1) begin
            pend_q <= 1'b1;
            cnt_q  <= 16'd1;
        end else if (pend_q) begin
            if (done) pend_q <= 1'b0;
            else      cnt_q  <= cnt_q + 16'd1;
        end
    end

    assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_accept_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // covers load (R2), add (R3) and square (R6)
    assert_one_cycle_ops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op != 2'd1) |=> done);
    assert_mul_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && done) |-> (cnt_q == 16'(NDIG + 1)));
    assert_mul_not_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && cnt_q < 16'(NDIG + 1)) |-> !done);
endmodule

bind gf_alu_core gf_alu_checker #(.DIGIT(DIGIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done)
);

// File: tb/gf_alu_core_test.sv
module gf_alu_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIGIT = 7;
    localparam int NREG  = 8;
    localparam int M     = 163;
    localparam int MUL_LAT = (M + DIGIT - 1) / DIGIT + 1;
    localparam int NVEC  = 6;

    localparam logic [M-1:0] ONES = {M{1'b1}};
    localparam logic [M-1:0] VA [NVEC] = '{
        M'(1),
        M'(2),
        ONES,
        {3'b011, {5{32'h0F1E2D3C}}},
        '0,
        {3'b100, {5{32'h80000001}}}
    };
    localparam logic [M-1:0] VB [NVEC] = '{
        {3'b101, {5{32'hDEADBEEF}}},
        {1'b1, 162'b0},
        ONES,
        {3'b110, {5{32'h9A8B7C6D}}},
        ONES,
        {3'b001, {5{32'h13579BDF}}}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = '0;
    logic [2:0]   cmd_src_a = '0, cmd_src_b = '0, cmd_dst = '0;
    logic [M-1:0] cmd_data = '0;
    logic         busy, done;
    logic [M-1:0] res_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gf_alu_core #(.DIGIT(DIGIT), .NREG(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst),
        .cmd_data(cmd_data), .busy(busy), .done(done), .res_data(res_data)
    );

    // Schoolbook product then fold of the high half
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [2*M-2:0] p;
        p = '0;
        for (int i = 0; i < M; i++)
            if (b[i]) p = p ^ ({{(M-1){1'b0}}, a} << i);
        for (int i = 2*M-2; i >= M; i--) begin
            if (p[i]) begin
                p[i] = 1'b0;
                p[i-M+7] = ~p[i-M+7];
                p[i-M+6] = ~p[i-M+6];
                p[i-M+3] = ~p[i-M+3];
                p[i-M]   = ~p[i-M];
            end
        end
        return p[M-1:0];
    endfunction

    task automatic check_val(input string req, input string what,
                             input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [2:0] sa, input logic [2:0] sb,
                           input logic [2:0] dst, input logic [M-1:0] data,
                           output logic [M-1:0] res, output int lat);
        @(negedge clk);
        cmd_op = op; cmd_src_a = sa; cmd_src_b = sb; cmd_dst = dst; cmd_data = data;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        res = res_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [M-1:0] r, exp;
        int lat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check_int("R1", "busy after reset", int'(busy), 0);
        check_int("R1", "done after reset", int'(done), 0);

        run_cmd(2'd3, 3'd0, 3'd0, 3'd0, '0, r, lat);   // r0 = 0 for readback
        check_val("R2", "load zero", r, '0);

        for (int v = 0; v < NVEC; v++) begin
            run_cmd(2'd3, 3'd0, 3'd0, 3'd1, VA[v], r, lat);
            check_val("R2", "load A", r, VA[v]);
            check_int("R2", "load latency", lat, 1);
            run_cmd(2'd3, 3'd0, 3'd0, 3'd2, VB[v], r, lat);
            check_val("R2", "load B", r, VB[v]);

            run_cmd(2'd0, 3'd1, 3'd2, 3'd3, '0, r, lat);
            check_val("R3", "add", r, VA[v] ^ VB[v]);
            check_int("R3", "add latency", lat, 1);

            exp = ref_mul(VA[v], VB[v]);
            run_cmd(2'd1, 3'd1, 3'd2, 3'd4, '0, r, lat);
            check_val("R4", "multiply", r, exp);
            check_int("R5", "multiply latency", lat, MUL_LAT);
            run_cmd(2'd1, 3'd2, 3'd1, 3'd5, '0, r, lat);
            check_val("R4", "multiply swapped", r, exp);

            run_cmd(2'd0, 3'd4, 3'd0, 3'd7, '0, r, lat);
            check_val("R7", "readback of product", r, exp);

            run_cmd(2'd2, 3'd1, 3'd2, 3'd5, '0, r, lat);
            check_val("R6", "square A", r, ref_mul(VA[v], VA[v]));
            check_int("R6", "square latency", lat, 1);
            run_cmd(2'd2, 3'd2, 3'd1, 3'd5, '0, r, lat);
            check_val("R6", "square B (src_b ignored)", r, ref_mul(VB[v], VB[v]));
        end

        // R7: done lasts one cycle
        run_cmd(2'd0, 3'd1, 3'd2, 3'd3, '0, r, lat);
        @(negedge clk);
        check_int("R7", "done pulse width", int'(done), 0);

        // R8: command held during a multiply is ignored
        run_cmd(2'd3, 3'd0, 3'd0, 3'd6, VB[3], r, lat);
        @(negedge clk);
        cmd_op = 2'd1; cmd_src_a = 3'd1; cmd_src_b = 3'd2; cmd_dst = 3'd4; cmd_valid = 1'b1;
        @(negedge clk);
        check_int("R8", "busy after accept", int'(busy), 1);
        cmd_op = 2'd3; cmd_dst = 3'd6; cmd_data = VA[3];
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        check_int("R8", "busy during done", int'(busy), 1);
        run_cmd(2'd0, 3'd6, 3'd0, 3'd7, '0, r, lat);
        check_val("R8", "register untouched by busy command", r, VB[3]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule